// File: doc/BRIEF.md
# Delegated Interrupt Enable, Pending and Delegation Register File

This block holds the interrupt-enable, interrupt-pending and interrupt-delegation state for three privilege groups (machine, supervisor, virtual-supervisor), each with a soft, timer and external source. Software reaches this state through seven register views selected by a 3-bit code. Machine views see the raw bits. The supervisor views are masked aliases of the same bits that move onto the virtual-supervisor fields when the hart runs virtualized. The hypervisor views see only the virtual-supervisor fields.

Each access presents write data and a per-bit write mask. A view bit changes as `new = (old & ~mask) | (data & mask)`, after that view's own restrictions have cut the mask down. Read data is combinational. It shows the state before the access, so one access reads and writes at the same time. Hardware timer and external lines are ORed into the pending image. A hardware claim mask blocks software from touching the pending bits it names. Priority arbitration and trap entry belong to the consumer of `ieVec` and `ipVec`.

Bit layout, shared by all views except where shifted: SSIP=1, VSSIP=2, MSIP=3, STIP=5, VSTIP=6, MTIP=7, SEIP=9, VSEIP=10, MEIP=11. Group masks: machine 0x888, supervisor 0x222, virtual-supervisor 0x444, all interrupts 0xEEE, delegable 0x666.

Top module: `irq_csr_file`

## Requirements
- R1: After reset the enable, pending and delegation state are all zero: `ieVec`, `ipVec` (with `hwPend` low) and every view read return 0.
- R2: View code 0 (machine enable) reads the enable register. A write changes only bits in 0xEEE, and every other enable bit keeps its value.
- R3: View code 2 (delegation) reads the delegation register. Only bits in 0x666 are writable. With `HYP_EN`=1, bits 0x444 are set to one after every write access to this view, including one with a zero mask. Before the first such write they read zero.
- R4: View code 1 (machine pending) reads the pending image. A software write reaches only bits in 0x666 whose `hwClaim` bit is clear. Machine pending bits never change by software.
- R5: `hwPend` bits in 0xEE0 (timer and external) are ORed into the pending image, both in reads and on `ipVec`, so software cannot clear them. Other `hwPend` bits are ignored.
- R6: View code 3 (supervisor enable) reads enable AND delegation when not virtualized. When `virtOn`=1 it reads `((enable & delegation & 0x444) >> 1)`.
- R7: A write through view code 3 updates only the supervisor enable field 0x222 when not virtualized. When virtualized, data and mask are shifted left by one and only field 0x444 changes.
- R8: View code 4 (supervisor pending) cuts the write mask down to delegation AND 0x103, and then applies the R4 filter. It reads pending AND delegation. When virtualized, data and the 0x103-masked mask are shifted left by one, only VSSIP (bit 2) is writable, and the read returns `((pending & delegation & 0x444) >> 1)`.
- R9: View code 5 (hypervisor enable) reads and writes only enable bits 0x444.
- R10: View code 6 (hypervisor pending) reads pending AND 0x444. It writes only pending bits 0x444, under the R4 filter.
- R11: View code 7 is reserved. It reads zero, and writes to it change nothing.
- R12: A read returns the state from before the same access. Writes take effect at the next clock edge. With `accValid`=0 no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe; write takes effect at the clock edge |
| accSel | input | 3 | View code 0..7 |
| wrData | input | XLEN | Write data in the view's bit layout |
| wrMask | input | XLEN | Per-bit write mask in the view's bit layout |
| virtOn | input | 1 | Hart runs virtualized; redirects supervisor views |
| hwPend | input | XLEN | Hardware pending lines (timer/external bits used) |
| hwClaim | input | XLEN | Pending bits owned by hardware, blocked for software |
| rdData | output | XLEN | Read data of the selected view (pre-access state) |
| ieVec | output | XLEN | Raw enable register |
| ipVec | output | XLEN | Raw pending image (software OR hardware) |

## Verification
Reads and writes can fall in the same access. Every access is judged on the read value (the state before the access) and on the vectors one cycle later, so an early commit shows up as a miscompare. Hardware pending can also coincide with a software clear of the same bit, and a claim can coincide with a software write to that bit. The bench provokes both by driving `hwPend` or `hwClaim` together with an all-ones mask. Its model then expects the hardware bit to stay visible and the claimed bit to stay unchanged.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  parameter int XLEN = 32;

  localparam logic [XLEN-1:0] M_BITS   = XLEN'(32'h0000_0888);
  localparam logic [XLEN-1:0] S_BITS   = XLEN'(32'h0000_0222);
  localparam logic [XLEN-1:0] VS_BITS  = XLEN'(32'h0000_0444);
  localparam logic [XLEN-1:0] ALL_BITS = M_BITS | S_BITS | VS_BITS;
  localparam logic [XLEN-1:0] DLG_BITS = S_BITS | VS_BITS;
  localparam logic [XLEN-1:0] HW_BITS  = XLEN'(32'h0000_0EE0);
  localparam logic [XLEN-1:0] SIP_WR   = XLEN'(32'h0000_0103);
  localparam logic [XLEN-1:0] VSSIP_B  = XLEN'(32'h0000_0004);

  typedef enum logic [2:0] {
    SEL_MIE = 3'd0, SEL_MIP = 3'd1, SEL_DLG = 3'd2, SEL_SIE = 3'd3,
    SEL_SIP = 3'd4, SEL_HIE = 3'd5, SEL_HIP = 3'd6, SEL_RSV = 3'd7
  } viewSel_e;

  typedef enum logic [3:0] {
    RV_ZERO, RV_MIE, RV_MIP, RV_DLG, RV_SIE, RV_SIEV,
    RV_SIP, RV_SIPV, RV_HIE, RV_HIP
  } rdView_e;

  typedef struct packed {
    logic [XLEN-1:0] ieMask;
    logic [XLEN-1:0] ieData;
    logic [XLEN-1:0] dgMask;
    logic [XLEN-1:0] dgData;
    logic [XLEN-1:0] ipMask;
    logic [XLEN-1:0] ipData;
    logic            dgWr;
    rdView_e         rdView;
  } strobes_t;
endpackage

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [2:0]      accSel,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] wrMask,
  input  logic            virtOn,
  input  logic [XLEN-1:0] dgCur,
  output strobes_t        stb
);
  strobes_t raw;

  always_comb begin
    raw        = '0;
    raw.rdView = RV_ZERO;
    unique case (viewSel_e'(accSel))
      SEL_MIE: begin
        raw.rdView = RV_MIE;
        raw.ieMask = wrMask & ALL_BITS;
        raw.ieData = wrData;
      end
      SEL_MIP: begin
        raw.rdView = RV_MIP;
        raw.ipMask = wrMask;
        raw.ipData = wrData;
      end
      SEL_DLG: begin
        raw.rdView = RV_DLG;
        raw.dgMask = wrMask & DLG_BITS;
        raw.dgData = wrData;
        raw.dgWr   = 1'b1;
      end
      SEL_SIE: begin
        if (virtOn) begin
          raw.rdView = RV_SIEV;
          raw.ieMask = (wrMask << 1) & VS_BITS;
          raw.ieData = wrData << 1;
        end else begin
          raw.rdView = RV_SIE;
          raw.ieMask = wrMask & S_BITS;
          raw.ieData = wrData;
        end
      end
      SEL_SIP: begin
        if (virtOn) begin
          raw.rdView = RV_SIPV;
          raw.ipMask = ((wrMask & SIP_WR) << 1) & dgCur & VSSIP_B;
          raw.ipData = wrData << 1;
        end else begin
          raw.rdView = RV_SIP;
          raw.ipMask = wrMask & dgCur & SIP_WR;
          raw.ipData = wrData;
        end
      end
      SEL_HIE: begin
        raw.rdView = RV_HIE;
        raw.ieMask = wrMask & VS_BITS;
        raw.ieData = wrData;
      end
      SEL_HIP: begin
        raw.rdView = RV_HIP;
        raw.ipMask = wrMask & VS_BITS;
        raw.ipData = wrData;
      end
      default: raw.rdView = RV_ZERO;
    endcase
  end

  always_comb begin
    stb = raw;
    if (!accValid) begin
      stb.ieMask = '0;
      stb.dgMask = '0;
      stb.ipMask = '0;
      stb.dgWr   = 1'b0;
    end
  end

  // R11
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accSel == 3'd7) |-> (stb.ieMask == '0 && stb.ipMask == '0 && !stb.dgWr));

  // R7
  sie_virt_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accSel == 3'd3 && virtOn) |-> ((stb.ieMask & ~VS_BITS) == '0));
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [XLEN-1:0] hwPend,
  input  logic [XLEN-1:0] hwClaim,
  output logic [XLEN-1:0] dgCur,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] ieVec,
  output logic [XLEN-1:0] ipVec
);
  localparam logic [XLEN-1:0] DG_FORCE = HYP_EN ? VS_BITS : '0;

  logic [XLEN-1:0] ieReg, dgReg, swPend;
  logic [XLEN-1:0] ipEffMask, pendView;

  assign ipEffMask = stb.ipMask & DLG_BITS & ~hwClaim;
  assign pendView  = swPend | (hwPend & HW_BITS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieReg  <= '0;
      dgReg  <= '0;
      swPend <= '0;
    end else begin
      ieReg  <= (ieReg & ~stb.ieMask) | (stb.ieData & stb.ieMask);
      swPend <= (swPend & ~ipEffMask) | (stb.ipData & ipEffMask);
      if (stb.dgWr)
        dgReg <= (dgReg & ~stb.dgMask) | (stb.dgData & stb.dgMask) | DG_FORCE;
    end
  end

  always_comb begin
    unique case (stb.rdView)
      RV_MIE:  rdData = ieReg;
      RV_MIP:  rdData = pendView;
      RV_DLG:  rdData = dgReg;
      RV_SIE:  rdData = ieReg & dgReg;
      RV_SIEV: rdData = (ieReg & dgReg & VS_BITS) >> 1;
      RV_SIP:  rdData = pendView & dgReg;
      RV_SIPV: rdData = (pendView & dgReg & VS_BITS) >> 1;
      RV_HIE:  rdData = ieReg & VS_BITS;
      RV_HIP:  rdData = pendView & VS_BITS;
      default: rdData = '0;
    endcase
  end

  assign dgCur = dgReg;
  assign ieVec = ieReg;
  assign ipVec = pendView;

  // R2
  ie_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ieReg & ~ALL_BITS));

  // R4
  claim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hwClaim) |=> (((swPend ^ $past(swPend)) & $past(hwClaim)) == '0));

  // R4
  mpend_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(swPend & M_BITS));

  // R3
  dg_nondeleg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(dgReg & ~DLG_BITS));

  generate
    if (HYP_EN) begin : g_force
      // R3
      dg_force_chk: assert property (@(posedge clk) disable iff (!rstN)
        stb.dgWr |=> ((dgReg & VS_BITS) == VS_BITS));
    end
  endgenerate
endmodule

// File: rtl/irq_csr_file.sv
`timescale 1ns/1ps
module irq_csr_file
  import irq_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic [2:0]      accSel,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] wrMask,
  input  logic            virtOn,
  input  logic [XLEN-1:0] hwPend,
  input  logic [XLEN-1:0] hwClaim,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] ieVec,
  output logic [XLEN-1:0] ipVec
);
  strobes_t        stb;
  logic [XLEN-1:0] dgCur;

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSel(accSel),
    .wrData(wrData), .wrMask(wrMask), .virtOn(virtOn), .dgCur(dgCur), .stb(stb)
  );

  irq_regs #(.HYP_EN(HYP_EN)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .hwPend(hwPend), .hwClaim(hwClaim),
    .dgCur(dgCur), .rdData(rdData), .ieVec(ieVec), .ipVec(ipVec)
  );

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(ieVec));
endmodule

// File: tb/tb_irq_csr_file.sv
`timescale 1ns/1ps
module tb_irq_csr_file;
  import irq_pkg::*;

  localparam logic [XLEN-1:0] ONES = '1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            accValid = 1'b0;
  logic [2:0]      accSel = 3'd0;
  logic [XLEN-1:0] wrData = '0, wrMask = '0, hwPend = '0, hwClaim = '0;
  logic            virtOn = 1'b0;
  logic [XLEN-1:0] rdData, ieVec, ipVec;

  always #2 clk = ~clk;

  irq_csr_file #(.HYP_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSel(accSel),
    .wrData(wrData), .wrMask(wrMask), .virtOn(virtOn), .hwPend(hwPend),
    .hwClaim(hwClaim), .rdData(rdData), .ieVec(ieVec), .ipVec(ipVec)
  );

  typedef struct {
    logic [XLEN-1:0] expRd;
    logic [XLEN-1:0] expIe;
    logic [XLEN-1:0] expIp;
    bit              chkRd;
    string           tag;
  } item_t;

  item_t expQ[$];
  int nChecks = 0, nFails = 0;
  bit allSent = 1'b0;

  logic [XLEN-1:0] mIe = '0, mDg = '0, mSw = '0;

  function automatic logic [XLEN-1:0] viewOfPend(logic [XLEN-1:0] hp);
    return mSw | (hp & XLEN'(32'hEE0));
  endfunction

  task automatic compare(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: samples 1 ns after the falling edge, well away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        if (it.chkRd) compare(it.tag, "rdData", rdData, it.expRd);
        compare(it.tag, "ieVec", ieVec, it.expIe);
        compare(it.tag, "ipVec", ipVec, it.expIp);
      end
    end
  end

  // driver: one access per cycle, expected values from the requirement model
  task automatic access(input logic [2:0] sel, input logic [XLEN-1:0] d,
                        input logic [XLEN-1:0] m, input logic v,
                        input logic [XLEN-1:0] hp, input logic [XLEN-1:0] cl,
                        input bit valid, input string tag);
    item_t it;
    logic [XLEN-1:0] pv, rd, msk;
    @(negedge clk);
    accValid = valid; accSel = sel; wrData = d; wrMask = m;
    virtOn = v; hwPend = hp; hwClaim = cl;
    pv = viewOfPend(hp);
    case (sel)
      3'd0: rd = mIe;
      3'd1: rd = pv;
      3'd2: rd = mDg;
      3'd3: rd = v ? ((mIe & mDg & XLEN'(32'h444)) >> 1) : (mIe & mDg);
      3'd4: rd = v ? ((pv & mDg & XLEN'(32'h444)) >> 1) : (pv & mDg);
      3'd5: rd = mIe & XLEN'(32'h444);
      3'd6: rd = pv & XLEN'(32'h444);
      default: rd = '0;
    endcase
    it.expRd = rd; it.expIe = mIe; it.expIp = pv; it.chkRd = 1'b1; it.tag = tag;
    expQ.push_back(it);
    if (valid) begin
      case (sel)
        3'd0: begin msk = m & XLEN'(32'hEEE); mIe = (mIe & ~msk) | (d & msk); end
        3'd1: begin msk = m & XLEN'(32'h666) & ~cl; mSw = (mSw & ~msk) | (d & msk); end
        3'd2: begin
          msk = m & XLEN'(32'h666);
          mDg = (mDg & ~msk) | (d & msk) | XLEN'(32'h444);
        end
        3'd3: begin
          if (v) begin msk = (m << 1) & XLEN'(32'h444); mIe = (mIe & ~msk) | ((d << 1) & msk); end
          else   begin msk = m & XLEN'(32'h222); mIe = (mIe & ~msk) | (d & msk); end
        end
        3'd4: begin
          if (v) begin
            msk = ((m & XLEN'(32'h103)) << 1) & mDg & XLEN'(32'h4) & XLEN'(32'h666) & ~cl;
            mSw = (mSw & ~msk) | ((d << 1) & msk);
          end else begin
            msk = m & mDg & XLEN'(32'h103) & XLEN'(32'h666) & ~cl;
            mSw = (mSw & ~msk) | (d & msk);
          end
        end
        3'd5: begin msk = m & XLEN'(32'h444); mIe = (mIe & ~msk) | (d & msk); end
        3'd6: begin msk = m & XLEN'(32'h444) & ~cl; mSw = (mSw & ~msk) | (d & msk); end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [2:0] sel, input logic v, input logic [XLEN-1:0] hp, input string tag);
    access(sel, '0, '0, v, hp, '0, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state across views
    rd(3'd0, 1'b0, '0, "R1 mie after reset");
    rd(3'd2, 1'b0, '0, "R1 R3 deleg zero before first write");
    rd(3'd1, 1'b0, '0, "R1 pending after reset");
    // R2: machine enable, all ones then a single-bit clear
    access(3'd0, ONES, ONES, 1'b0, '0, '0, 1'b1, "R2 mie set all");
    access(3'd0, '0, XLEN'(32'h8), 1'b0, '0, '0, 1'b1, "R2 R12 mie clear MSIE read old");
    rd(3'd0, 1'b0, '0, "R2 mie after clear");
    // R3: delegation
    access(3'd2, ONES, ONES, 1'b0, '0, '0, 1'b1, "R3 deleg write ones");
    access(3'd2, '0, ONES, 1'b0, '0, '0, 1'b1, "R3 deleg clear all");
    rd(3'd2, 1'b0, '0, "R3 deleg VS forced");
    access(3'd2, ONES, XLEN'(32'h222), 1'b0, '0, '0, 1'b1, "R3 deleg set S field");
    // R4: machine pending with claim coinciding with the write
    access(3'd1, ONES, ONES, 1'b0, '0, XLEN'(32'h20), 1'b1, "R4 pend set with STIP claimed");
    access(3'd1, '0, ONES, 1'b0, '0, XLEN'(32'h600), 1'b1, "R4 pend clear with SEIP/VSEIP claimed");
    rd(3'd1, 1'b0, '0, "R4 pend after claimed clear");
    // R5: hardware lines coincide with a software clear
    access(3'd1, '0, ONES, 1'b0, XLEN'(32'h0A8), '0, 1'b1, "R5 hw pend with sw clear");
    rd(3'd1, 1'b0, XLEN'(32'h0A8), "R5 hw bits stay visible");
    rd(3'd1, 1'b0, '0, "R5 hw released");
    // R6/R7: supervisor enable views
    access(3'd0, XLEN'(32'h666), ONES, 1'b0, '0, '0, 1'b1, "R2 mie pattern");
    rd(3'd3, 1'b0, '0, "R6 sie plain read");
    rd(3'd3, 1'b1, '0, "R6 sie virt read");
    access(3'd3, '0, ONES, 1'b1, '0, '0, 1'b1, "R7 sie virt clear");
    rd(3'd0, 1'b0, '0, "R7 virt write touched VS field only");
    access(3'd3, '0, ONES, 1'b0, '0, '0, 1'b1, "R7 sie plain clear");
    access(3'd3, XLEN'(32'h222), XLEN'(32'h222), 1'b1, '0, '0, 1'b1, "R7 sie virt set");
    rd(3'd3, 1'b1, '0, "R6 R7 sie virt readback");
    rd(3'd0, 1'b0, '0, "R7 mie after virt set");
    // R8: supervisor pending views
    access(3'd4, ONES, ONES, 1'b0, '0, '0, 1'b1, "R8 sip plain set");
    rd(3'd4, 1'b0, '0, "R8 sip plain read");
    access(3'd4, ONES, ONES, 1'b1, '0, '0, 1'b1, "R8 sip virt set");
    rd(3'd4, 1'b1, '0, "R8 sip virt read");
    access(3'd4, '0, ONES, 1'b1, '0, XLEN'(32'h4), 1'b1, "R8 R4 sip virt clear claimed");
    access(3'd4, '0, ONES, 1'b1, '0, '0, 1'b1, "R8 sip virt clear");
    rd(3'd1, 1'b0, '0, "R8 pend after virt clear");
    // R9/R10: hypervisor views
    access(3'd5, ONES, ONES, 1'b0, '0, '0, 1'b1, "R9 hie set");
    access(3'd5, '0, ONES, 1'b0, '0, '0, 1'b1, "R9 hie clear");
    rd(3'd0, 1'b0, '0, "R9 mie after hie clear");
    access(3'd6, ONES, ONES, 1'b0, '0, '0, 1'b1, "R10 hip set");
    rd(3'd6, 1'b0, XLEN'(32'h440), "R10 hip read with hw");
    rd(3'd1, 1'b0, '0, "R10 pend only VS set");
    // R11: reserved view
    access(3'd7, ONES, ONES, 1'b0, '0, '0, 1'b1, "R11 reserved write");
    access(3'd7, ONES, ONES, 1'b1, '0, '0, 1'b1, "R11 reserved write virt");
    rd(3'd0, 1'b0, '0, "R11 mie unchanged");
    rd(3'd1, 1'b0, '0, "R11 pend unchanged");
    // R12: idle accesses leave state alone
    access(3'd0, ONES, ONES, 1'b0, '0, '0, 1'b0, "R12 idle mie");
    access(3'd2, '0, ONES, 1'b0, '0, '0, 1'b0, "R12 idle deleg");
    access(3'd1, '0, ONES, 1'b0, '0, '0, 1'b0, "R12 idle pend");
    rd(3'd2, 1'b0, '0, "R12 deleg unchanged");
    rd(3'd0, 1'b0, '0, "R12 mie unchanged");
    @(negedge clk);
    accValid = 1'b0;
    allSent = 1'b1;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule